// File: doc/BRIEF.md
# Reorder Buffer with Squash-After Commit

This block is a single-thread reorder buffer that retires instructions strictly in program order. The front end places instructions at the tail. Each one receives a buffer slot index and an increasing sequence number, and it carries its PC and a squash-after attribute. Execution reports completion by slot index. The oldest entry retires once it is complete, and at most one entry retires per cycle.

Some instructions change state that instructions already fetched behind them may depend on. A write to the address-space identifier register is the usual case. Stalling rename is not enough for these. If the retiring entry carries the squash-after attribute, it still retires normally. In the same cycle its commit is reported, the block sends a one-cycle squash message to the front end. That message names the retiring instruction as the last surviving one, carries the address of the next instruction as the refetch point, clears the misprediction flag and raises a squashing indication. During that one squashing cycle, every younger entry is discarded and allocation is refused. Allocation resumes on the next cycle.

Top module: `rob_squash_after`

## Requirements
- R1: After reset the buffer is empty (`robEmpty`=1, `robFull`=0), `allocReady`=1, `commitValid`=0, `sqValid`=0, and the first allocation gets slot 0 and sequence number 1.
- R2: Each accepted allocation (`allocValid` and `allocReady` high at a clock edge) takes slot `allocIdx` and sequence number `allocSeq`. Slots advance by one modulo DEPTH and sequence numbers advance by one. `youngestSeq` then equals the sequence number just allocated.
- R3: Retirement is in order. An entry whose completion has been written retires only once every older entry has retired, and an incomplete oldest entry blocks all younger completed ones. `commitValid`, `commitSeq` and `commitPc` appear one cycle after the cycle in which the entry becomes retirable.
- R4: With DEPTH entries in flight, `robFull`=1 and `allocReady`=0. A request made then is dropped and consumes no sequence number.
- R5: An entry with the squash-after attribute is itself retired. In the cycle its commit is reported, `sqValid`=1, `sqBusy`=1, `sqMispredict`=0, `sqSeq` equals its sequence number, and `sqPc` equals its PC plus INST_BYTES (4).
- R6: `sqValid` and `sqBusy` are high for exactly one cycle per squash-after retirement.
- R7: Every entry younger than a squash-after entry is discarded and never retires, even if it completed earlier or completes later. The buffer reads empty the cycle after the squash message.
- R8: In the squash cycle `youngestSeq` equals the retiring squash-after entry's sequence number.
- R9: Allocation is refused while `sqValid` is high and resumes on the next cycle. The new entry takes the slot just after the squash-after entry, and its sequence number continues from the last one handed out.
- R10: At most one entry retires per cycle. Two ready entries retire in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Allocation request |
| allocPc | input | PCW | PC of the instruction being allocated |
| allocSquashAfter | input | 1 | Squash-after attribute of the instruction being allocated |
| allocReady | output | 1 | Buffer accepts an allocation this cycle |
| allocIdx | output | IDXW | Slot the next allocation will occupy |
| allocSeq | output | SEQW | Sequence number the next allocation will receive |
| cmplValid | input | 1 | Completion write |
| cmplIdx | input | IDXW | Slot being marked complete |
| commitValid | output | 1 | An entry retired (registered) |
| commitSeq | output | SEQW | Sequence number of the retired entry |
| commitPc | output | PCW | PC of the retired entry |
| sqValid | output | 1 | Squash request to earlier stages |
| sqBusy | output | 1 | Buffer is in its squashing cycle |
| sqMispredict | output | 1 | Misprediction flag of the squash message, always 0 |
| sqSeq | output | SEQW | Last sequence number that stays valid |
| sqPc | output | PCW | Refetch address |
| youngestSeq | output | SEQW | Youngest valid sequence number |
| robFull | output | 1 | All DEPTH slots in use |
| robEmpty | output | 1 | No slot in use |

## Verification
A completion write captured at edge C makes the entry retirable in the following cycle. Its commit and any squash message are therefore registered at edge C+1 and checked at the falling edge after C+1. The flush takes effect at C+2, so emptiness and a restored `allocReady` are checked one falling edge later. `allocIdx`, `allocSeq` and `allocReady` are combinational, so they are sampled at the falling edge just before the edge that accepts the request. A monitor checks every commit at each falling edge to confirm that sequence numbers strictly increase and that no discarded number ever appears.

// File: rtl/robsq_pkg.sv
package robsq_pkg;

  // Strobes from the control path to the entry storage
  typedef struct packed {
    logic allocWe;   // write a new entry at the tail slot
    logic commitRe;  // retire the head slot
    logic cmplWe;    // mark a slot complete
    logic flushAll;  // discard every entry
  } robStrobes_t;

  typedef enum logic [0:0] {
    CM_RUN    = 1'b0,
    CM_SQUASH = 1'b1
  } commitState_t;

endpackage

// File: rtl/robsq_store.sv
module robsq_store
  import robsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PCW   = 32,
  parameter int SEQW  = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobes_t       strb,
  input  logic [IDXW-1:0]   wrIdx,
  input  logic [SEQW-1:0]   wrSeq,
  input  logic [PCW-1:0]    wrPc,
  input  logic              wrSa,
  input  logic [IDXW-1:0]   doneIdx,
  input  logic [IDXW-1:0]   headIdx,
  output logic              headValid,
  output logic              headDone,
  output logic              headSa,
  output logic [SEQW-1:0]   headSeq,
  output logic [PCW-1:0]    headPc
);

  logic [DEPTH-1:0] entValid;
  logic [DEPTH-1:0] entDone;
  logic [DEPTH-1:0] entSa;
  logic [SEQW-1:0]  entSeq [DEPTH];
  logic [PCW-1:0]   entPc  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic allocHit;
    logic retireHit;
    logic doneHit;

    assign allocHit  = strb.allocWe  && (wrIdx   == IDXW'(i));
    assign retireHit = strb.commitRe && (headIdx == IDXW'(i));
    assign doneHit   = strb.cmplWe   && (doneIdx == IDXW'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
      end else if (strb.flushAll) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
      end else if (allocHit) begin
        entValid[i] <= 1'b1;
        entDone[i]  <= 1'b0;
      end else begin
        if (retireHit) begin
          entValid[i] <= 1'b0;
          entDone[i]  <= 1'b0;
        end else if (doneHit && entValid[i]) begin
          entDone[i] <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entSa[i]  <= 1'b0;
        entSeq[i] <= '0;
        entPc[i]  <= '0;
      end else if (allocHit && !strb.flushAll) begin
        entSa[i]  <= wrSa;
        entSeq[i] <= wrSeq;
        entPc[i]  <= wrPc;
      end
    end
  end

  assign headValid = entValid[headIdx];
  assign headDone  = entDone[headIdx];
  assign headSa    = entSa[headIdx];
  assign headSeq   = entSeq[headIdx];
  assign headPc    = entPc[headIdx];

  // R4: the control never allocates over a slot still in flight
  p_alloc_free_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocWe |-> !entValid[wrIdx]);

  // R7: a flush leaves no valid slot behind
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (entValid == '0));

endmodule

// File: rtl/robsq_ctrl.sv
module robsq_ctrl
  import robsq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int PCW       = 32,
  parameter int SEQW      = 16,
  parameter int INST_BYTES = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic              cmplValid,
  input  logic              headValid,
  input  logic              headDone,
  input  logic              headSa,
  input  logic [SEQW-1:0]   headSeq,
  input  logic [PCW-1:0]    headPc,
  output robStrobes_t       strb,
  output logic [IDXW-1:0]   headIdx,
  output logic [IDXW-1:0]   tailIdx,
  output logic [SEQW-1:0]   nextSeq,
  output logic              allocReady,
  output logic              commitValid,
  output logic [SEQW-1:0]   commitSeq,
  output logic [PCW-1:0]    commitPc,
  output logic              sqValid,
  output logic              sqBusy,
  output logic [SEQW-1:0]   sqSeq,
  output logic [PCW-1:0]    sqPc,
  output logic [SEQW-1:0]   youngestSeq,
  output logic              robFull,
  output logic              robEmpty
);

  localparam logic [CNTW-1:0] FULL_COUNT = CNTW'(DEPTH);
  localparam logic [IDXW-1:0] LAST_IDX   = IDXW'(DEPTH - 1);

  commitState_t    stateQ;
  logic [IDXW-1:0] headQ;
  logic [IDXW-1:0] tailQ;
  logic [CNTW-1:0] countQ;
  logic [SEQW-1:0] seqQ;
  logic [SEQW-1:0] youngQ;

  logic commitFire;
  logic squashFire;
  logic allocFire;

  function automatic logic [IDXW-1:0] bumpIdx(input logic [IDXW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign commitFire = (stateQ == CM_RUN) && headValid && headDone;
  assign squashFire = commitFire && headSa;
  assign allocReady = (stateQ == CM_RUN) && (countQ != FULL_COUNT) && !squashFire;
  assign allocFire  = allocValid && allocReady;

  always_comb begin
    strb          = '0;
    strb.allocWe  = allocFire;
    strb.commitRe = commitFire;
    strb.cmplWe   = cmplValid;
    strb.flushAll = (stateQ == CM_SQUASH);
  end

  // Pointers, occupancy and commit state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= CM_RUN;
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else if (stateQ == CM_SQUASH) begin
      stateQ <= CM_RUN;
      tailQ  <= headQ;
      countQ <= '0;
    end else begin
      stateQ <= squashFire ? CM_SQUASH : CM_RUN;
      if (commitFire) headQ <= bumpIdx(headQ);
      if (allocFire)  tailQ <= bumpIdx(tailQ);
      case ({allocFire, commitFire})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  // Sequence numbering
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ   <= SEQW'(1);
      youngQ <= '0;
    end else begin
      if (allocFire) seqQ <= seqQ + 1'b1;
      if (squashFire)     youngQ <= headSeq;
      else if (allocFire) youngQ <= seqQ;
    end
  end

  // Registered retirement and squash messages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitValid <= 1'b0;
      commitSeq   <= '0;
      commitPc    <= '0;
      sqValid     <= 1'b0;
      sqBusy      <= 1'b0;
      sqSeq       <= '0;
      sqPc        <= '0;
    end else begin
      commitValid <= commitFire;
      sqValid     <= squashFire;
      sqBusy      <= squashFire;
      if (commitFire) begin
        commitSeq <= headSeq;
        commitPc  <= headPc;
      end
      if (squashFire) begin
        sqSeq <= headSeq;
        sqPc  <= headPc + PCW'(INST_BYTES);
      end
    end
  end

  assign headIdx     = headQ;
  assign tailIdx     = tailQ;
  assign nextSeq     = seqQ;
  assign youngestSeq = youngQ;
  assign robFull     = (countQ == FULL_COUNT);
  assign robEmpty    = (countQ == '0);

  // R4: occupancy never passes the depth
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= FULL_COUNT);

  // R5: the squash message goes out together with the matching commit
  p_squash_with_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |-> (commitValid && (commitSeq == sqSeq) && sqBusy));

  // R6: the squash message is a single-cycle pulse
  p_squash_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |=> !sqValid);

  // R7: the cycle after the squash the buffer is empty
  p_empty_after_squash_r7: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |=> robEmpty);

  // R8: youngest sequence number collapses to the squashing instruction
  p_youngest_on_squash_r8: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |-> (youngestSeq == sqSeq));

  // R9: no allocation while squashing
  p_no_alloc_squash_r9: assert property (@(posedge clk) disable iff (!rstN)
    sqBusy |-> !allocReady);

  // R10: a retirement never repeats the previous sequence number
  p_single_retire_r10: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && $past(commitValid)) |-> (commitSeq != $past(commitSeq)));

endmodule

// File: rtl/rob_squash_after.sv
module rob_squash_after
  import robsq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int PCW        = 32,
  parameter int SEQW       = 16,
  parameter int INST_BYTES = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [PCW-1:0]    allocPc,
  input  logic              allocSquashAfter,
  output logic              allocReady,
  output logic [IDXW-1:0]   allocIdx,
  output logic [SEQW-1:0]   allocSeq,
  input  logic              cmplValid,
  input  logic [IDXW-1:0]   cmplIdx,
  output logic              commitValid,
  output logic [SEQW-1:0]   commitSeq,
  output logic [PCW-1:0]    commitPc,
  output logic              sqValid,
  output logic              sqBusy,
  output logic              sqMispredict,
  output logic [SEQW-1:0]   sqSeq,
  output logic [PCW-1:0]    sqPc,
  output logic [SEQW-1:0]   youngestSeq,
  output logic              robFull,
  output logic              robEmpty
);

  robStrobes_t     strb;
  logic [IDXW-1:0] headIdx;
  logic            headValid;
  logic            headDone;
  logic            headSa;
  logic [SEQW-1:0] headSeq;
  logic [PCW-1:0]  headPc;

  robsq_ctrl #(
    .DEPTH(DEPTH), .PCW(PCW), .SEQW(SEQW), .INST_BYTES(INST_BYTES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .cmplValid(cmplValid),
    .headValid(headValid), .headDone(headDone), .headSa(headSa),
    .headSeq(headSeq), .headPc(headPc),
    .strb(strb), .headIdx(headIdx), .tailIdx(allocIdx), .nextSeq(allocSeq),
    .allocReady(allocReady),
    .commitValid(commitValid), .commitSeq(commitSeq), .commitPc(commitPc),
    .sqValid(sqValid), .sqBusy(sqBusy), .sqSeq(sqSeq), .sqPc(sqPc),
    .youngestSeq(youngestSeq), .robFull(robFull), .robEmpty(robEmpty)
  );

  robsq_store #(
    .DEPTH(DEPTH), .PCW(PCW), .SEQW(SEQW)
  ) uStore (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrIdx(allocIdx), .wrSeq(allocSeq), .wrPc(allocPc), .wrSa(allocSquashAfter),
    .doneIdx(cmplIdx), .headIdx(headIdx),
    .headValid(headValid), .headDone(headDone), .headSa(headSa),
    .headSeq(headSeq), .headPc(headPc)
  );

  // This flush is never branch recovery
  assign sqMispredict = 1'b0;

endmodule

// File: tb/rob_squash_after_test.sv
`timescale 1ns/1ps
module rob_squash_after_test;

  localparam int DEPTH = 8;
  localparam int PCW   = 32;
  localparam int SEQW  = 16;
  localparam int IDXW  = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            allocValid = 1'b0;
  logic [PCW-1:0]  allocPc = '0;
  logic            allocSquashAfter = 1'b0;
  logic            allocReady;
  logic [IDXW-1:0] allocIdx;
  logic [SEQW-1:0] allocSeq;
  logic            cmplValid = 1'b0;
  logic [IDXW-1:0] cmplIdx = '0;
  logic            commitValid;
  logic [SEQW-1:0] commitSeq;
  logic [PCW-1:0]  commitPc;
  logic            sqValid, sqBusy, sqMispredict;
  logic [SEQW-1:0] sqSeq;
  logic [PCW-1:0]  sqPc;
  logic [SEQW-1:0] youngestSeq;
  logic            robFull, robEmpty;

  int checks = 0;
  int fails = 0;
  int lastCommitted = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rob_squash_after #(.DEPTH(DEPTH), .PCW(PCW), .SEQW(SEQW)) uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R3 / R7: every commit strictly follows the previous one in sequence order
  always @(negedge clk) begin
    if (rstN && commitValid) begin
      chk(int'(commitSeq) > lastCommitted, "R3 in-order commit", commitSeq, lastCommitted + 1);
      lastCommitted = int'(commitSeq);
    end
  end

  task automatic alloc(input logic [PCW-1:0] pc, input bit sa,
                       input int expIdx, input int expSeq, input string req);
    @(negedge clk);
    chk(allocReady, req, allocReady, 1);
    chk(int'(allocIdx) == expIdx, req, allocIdx, expIdx);
    chk(int'(allocSeq) == expSeq, req, allocSeq, expSeq);
    allocValid = 1'b1; allocPc = pc; allocSquashAfter = sa;
    @(negedge clk);
    allocValid = 1'b0; allocSquashAfter = 1'b0;
    chk(int'(youngestSeq) == expSeq, "R2 youngest after alloc", youngestSeq, expSeq);
  endtask

  task automatic complete(input int idx);
    @(negedge clk);
    cmplValid = 1'b1; cmplIdx = IDXW'(idx);
    @(negedge clk);
    cmplValid = 1'b0;
  endtask

  task automatic expectCommit(input int seq, input string req);
    @(negedge clk);
    chk(commitValid, req, commitValid, 1);
    chk(int'(commitSeq) == seq, req, commitSeq, seq);
  endtask

  task automatic expectNoCommit(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(!commitValid, req, commitValid, 0);
    end
  endtask

  task automatic testReset();
    chk(robEmpty && !robFull, "R1 empty after reset", {robFull, robEmpty}, 2'b01);
    chk(allocReady, "R1 ready after reset", allocReady, 1);
    chk(!commitValid && !sqValid, "R1 no outputs after reset", {commitValid, sqValid}, 0);
    chk(allocIdx == 0 && allocSeq == 1, "R1 first slot/seq", {allocIdx, allocSeq}, 1);
  endtask

  task automatic testInOrder();
    alloc(32'h1000, 0, 0, 1, "R2 alloc 0");
    alloc(32'h1004, 0, 1, 2, "R2 alloc 1");
    alloc(32'h1008, 0, 2, 3, "R2 alloc 2");
    complete(1);
    expectNoCommit(3, "R3 head incomplete blocks younger");
    complete(0);
    expectCommit(1, "R10 first of pair");
    chk(commitPc == 32'h1000, "R3 commit pc", commitPc, 32'h1000);
    expectCommit(2, "R10 second of pair next cycle");
    expectNoCommit(1, "R3 seq3 still incomplete");
    complete(2);
    expectCommit(3, "R3 last entry");
    @(negedge clk);
    chk(robEmpty, "R3 drained", robEmpty, 1);
  endtask

  task automatic testFull();
    for (int i = 0; i < DEPTH; i++)
      alloc(32'h2000 + 4 * i, 0, (3 + i) % DEPTH, 4 + i, "R2 fill");
    chk(robFull && !allocReady, "R4 full refuses", {robFull, allocReady}, 2'b10);
    @(negedge clk);
    allocValid = 1'b1; allocPc = 32'hdead;
    @(negedge clk);
    allocValid = 1'b0;
    chk(robFull && allocSeq == 12, "R4 refused request consumes nothing", allocSeq, 12);
    complete(3);
    expectCommit(4, "R4 head of full buffer");
    alloc(32'h3000, 0, 3, 12, "R4 seq after refused request");
    for (int i = 0; i < DEPTH; i++) complete((4 + i) % DEPTH);
    expectNoCommit(0, "");
    repeat (4) @(negedge clk);
    chk(robEmpty && lastCommitted == 12, "R3 all retired", lastCommitted, 12);
  endtask

  task automatic testSquashAfter();
    alloc(32'h100, 1, 4, 13, "R2 squash-after entry");
    alloc(32'h104, 0, 5, 14, "R2 younger 1");
    alloc(32'h108, 0, 6, 15, "R2 younger 2");
    complete(5);
    complete(6);
    expectNoCommit(1, "R3 blocked behind squash-after");
    complete(4);
    @(negedge clk);
    chk(commitValid && commitSeq == 13, "R5 squash-after itself retires", commitSeq, 13);
    chk(sqValid && sqBusy, "R5 squash and busy", {sqValid, sqBusy}, 2'b11);
    chk(!sqMispredict, "R5 no mispredict", sqMispredict, 0);
    chk(sqSeq == 13, "R5 surviving seq", sqSeq, 13);
    chk(sqPc == 32'h104, "R5 refetch pc", sqPc, 32'h104);
    chk(youngestSeq == 13, "R8 youngest collapses", youngestSeq, 13);
    chk(!allocReady, "R9 refused while squashing", allocReady, 0);
    @(negedge clk);
    chk(!sqValid && !sqBusy, "R6 single-cycle squash", {sqValid, sqBusy}, 0);
    chk(!commitValid, "R7 completed younger dropped", commitValid, 1'b0);
    chk(robEmpty, "R7 empty after squash", robEmpty, 1);
    chk(allocReady, "R9 allocation resumes", allocReady, 1);
    complete(6);
    expectNoCommit(3, "R7 late completion of flushed slot");
    alloc(32'h104, 0, 5, 16, "R9 refill after squash");
    complete(5);
    expectCommit(16, "R9 refetched instruction retires");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInOrder();
    testFull();
    testSquashAfter();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule